// File: doc/BRIEF.md
# Register Rename Map Table

This block sits at the dispatch point of an out-of-order core. It maps a small set of architectural registers onto a larger pool of physical registers. Every architectural entry holds the tag of the physical register that currently holds, or will later hold, its value, together with a ready flag. The physical register file keeps one data word and one valid flag per physical register.

Each cycle one instruction may present two source register names and one destination name. For each source the block returns a ready flag and an operand word. The operand word is the data value when the mapping is ready. It is the physical tag, zero-extended, when the mapping is still waiting. A writeback arriving in the same cycle is forwarded to the sources. The destination receives a fresh physical register from a FIFO free list and is marked not ready, even if an older write to it is still pending. Freed tags return to the list through a release port.

Writeback sets the physical valid flag. It also sets the ready flag of any architectural entry that still points at that tag.

Top module: `reg_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i and is ready, every architectural value reads as zero, and the free list holds tags NUM_ARCH up to NUM_PHYS-1 with the lowest tag at the head.
- R2: A source whose mapping is ready returns src_*_rdy=1, and src_*_opnd carries the physical register's data value.
- R3: A source whose mapping is not ready, with no matching writeback in that cycle, returns src_*_rdy=0, and src_*_opnd carries the physical tag zero-extended in its low bits.
- R4: A dispatch fires when disp_valid=1 and disp_ready=1. It returns the free-list head on dst_tag. From the next cycle the destination maps to that tag, not ready. The sources of the same instruction see the mapping as it stood before the remap.
- R5: A dispatch fires even when its destination already has a pending write. Later readers of that register see the newest tag.
- R6: When the free list is empty, disp_ready=0. A dispatch presented in that cycle changes no mapping and consumes no tag.
- R7: A writeback (wb_valid=1) stores wb_data in physical register wb_tag. Any architectural entry that maps to wb_tag becomes ready. A writeback to a tag that no entry maps to leaves every mapping unchanged.
- R8: When a source maps to a not-ready tag that equals wb_tag while wb_valid=1, the source returns rdy=1 with wb_data in the same cycle.
- R9: If a dispatch remaps a destination in the same cycle that its old tag is written back, the new mapping stays not ready.
- R10: A released tag (rel_valid=1) joins the tail of the free list. It can be allocated from the following cycle, and disp_ready rises then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Instruction presented for dispatch |
| disp_src_a | input | 3 | First source architectural register |
| disp_src_b | input | 3 | Second source architectural register |
| disp_dst | input | 3 | Destination architectural register |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | 3 | Physical tag being written back |
| wb_data | input | 16 | Writeback value |
| rel_valid | input | 1 | Release strobe for a physical tag |
| rel_tag | input | 3 | Physical tag returned to the free list |
| disp_ready | output | 1 | Free list not empty; dispatch can fire |
| dst_tag | output | 3 | Physical tag allocated to the destination |
| src_a_rdy | output | 1 | First source operand is a value |
| src_a_opnd | output | 16 | First source value or zero-extended tag |
| src_b_rdy | output | 1 | Second source operand is a value |
| src_b_opnd | output | 16 | Second source value or zero-extended tag |

## Verification
The bench aims at three kinds of hazard: a source naming its own destination, a second write to a register that is already pending, and a writeback that lands in the same cycle as a read or a remap. A design that applied the remap before the source lookup would hand the instruction its own new tag. A design without forwarding would return a stale tag. A design that let a writeback of the old tag mark the new mapping ready would release readers early. The bench also drains the free list and then refills it. A design that allocated while empty, or that ignored a release, shows a wrong disp_ready or a wrong dst_tag.

// File: rtl/rrm_pkg.sv
`timescale 1ns/1ps
package rrm_pkg;
    localparam int DEF_NUM_ARCH = 5;
    localparam int DEF_NUM_PHYS = 8;
    localparam int DEF_DATA_W   = 16;

    // Where a source operand comes from this cycle
    typedef enum logic [1:0] {
        OPND_PRF = 2'd0,  // committed value in the physical file
        OPND_FWD = 2'd1,  // writeback bypass
        OPND_TAG = 2'd2   // still pending: hand out the tag
    } opnd_src_e;

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rrm_free_list.sv
`timescale 1ns/1ps
module rrm_free_list #(
    parameter int NUM_ARCH = rrm_pkg::DEF_NUM_ARCH,
    parameter int NUM_PHYS = rrm_pkg::DEF_NUM_PHYS
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     pop,
    input  logic                                     push,
    input  logic [rrm_pkg::width_of(NUM_PHYS)-1:0]   push_tag,
    output logic [rrm_pkg::width_of(NUM_PHYS)-1:0]   head_tag,
    output logic                                     nonempty
);
    localparam int TAG_W  = rrm_pkg::width_of(NUM_PHYS);
    localparam int CNT_W  = $clog2(NUM_PHYS + 1);
    localparam int INIT_N = NUM_PHYS - NUM_ARCH;

    logic [TAG_W-1:0] slots [NUM_PHYS];
    logic [TAG_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] fill;

    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
        return (p == TAG_W'(NUM_PHYS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++)
                slots[i] <= (i < INIT_N) ? TAG_W'(NUM_ARCH + i) : '0;
            rd_ptr <= '0;
            wr_ptr <= TAG_W'(INIT_N);
            fill   <= CNT_W'(INIT_N);
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_tag;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop)
                rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    assign head_tag = slots[rd_ptr];
    assign nonempty = (fill != '0);

    // R6: never allocate from an empty list
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fill != '0));
    // R10: a release never overfills the list
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        push |-> (fill < CNT_W'(NUM_PHYS)));
    // R10: a release is visible as one more entry next cycle
    p_release_counts_r10: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (fill == $past(fill) + 1'b1));
endmodule

// File: rtl/rrm_phys_file.sv
`timescale 1ns/1ps
module rrm_phys_file #(
    parameter int NUM_ARCH = rrm_pkg::DEF_NUM_ARCH,
    parameter int NUM_PHYS = rrm_pkg::DEF_NUM_PHYS,
    parameter int DATA_W   = rrm_pkg::DEF_DATA_W,
    parameter int NRD      = 2
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     alloc_en,
    input  logic [rrm_pkg::width_of(NUM_PHYS)-1:0]   alloc_tag,
    input  logic                                     wb_valid,
    input  logic [rrm_pkg::width_of(NUM_PHYS)-1:0]   wb_tag,
    input  logic [DATA_W-1:0]                        wb_data,
    input  logic [rrm_pkg::width_of(NUM_PHYS)-1:0]   rd_tag  [NRD],
    output logic [DATA_W-1:0]                        rd_data [NRD],
    output logic [NUM_PHYS-1:0]                      vld
);
    localparam int TAG_W = rrm_pkg::width_of(NUM_PHYS);

    logic [DATA_W-1:0] words [NUM_PHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                words[i] <= '0;
                vld[i]   <= (i < NUM_ARCH);
            end
        end else begin
            if (wb_valid) begin
                words[wb_tag] <= wb_data;
                vld[wb_tag]   <= 1'b1;
            end
            if (alloc_en)
                vld[alloc_tag] <= 1'b0;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = words[rd_tag[g]];
    end

    // R7: a writeback leaves its register valid unless reallocated at once
    p_wb_sets_valid_r7: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !(alloc_en && alloc_tag == wb_tag)) |=> vld[$past(wb_tag)]);
    // R4: a freshly allocated register is not valid
    p_alloc_clears_r4: assert property (@(posedge clk) disable iff (rst)
        alloc_en |=> !vld[$past(alloc_tag)]);
endmodule

// File: rtl/rrm_map_table.sv
`timescale 1ns/1ps
module rrm_map_table #(
    parameter int NUM_ARCH = rrm_pkg::DEF_NUM_ARCH,
    parameter int NUM_PHYS = rrm_pkg::DEF_NUM_PHYS,
    parameter int NRD      = 2
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [rrm_pkg::width_of(NUM_ARCH)-1:0]   rd_arch [NRD],
    output logic [rrm_pkg::width_of(NUM_PHYS)-1:0]   rd_tag  [NRD],
    output logic                                     rd_rdy  [NRD],
    input  logic                                     wr_en,
    input  logic [rrm_pkg::width_of(NUM_ARCH)-1:0]   wr_arch,
    input  logic [rrm_pkg::width_of(NUM_PHYS)-1:0]   wr_tag,
    input  logic                                     wb_valid,
    input  logic [rrm_pkg::width_of(NUM_PHYS)-1:0]   wb_tag
);
    localparam int ARCH_W = rrm_pkg::width_of(NUM_ARCH);
    localparam int TAG_W  = rrm_pkg::width_of(NUM_PHYS);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             rdy;
    } map_ent_t;

    map_ent_t ents [NUM_ARCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                ents[i].tag <= TAG_W'(i);
                ents[i].rdy <= 1'b1;
            end
        end else begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                if (wr_en && wr_arch == ARCH_W'(i)) begin
                    // newest writer wins over any writeback this cycle
                    ents[i].tag <= wr_tag;
                    ents[i].rdy <= 1'b0;
                end else if (wb_valid && ents[i].tag == wb_tag) begin
                    ents[i].rdy <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_tag[g] = ents[rd_arch[g]].tag;
        assign rd_rdy[g] = ents[rd_arch[g]].rdy;
    end

    // R4/R9: a remapped entry points at the new tag and waits
    p_remap_pending_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ents[$past(wr_arch)].tag == $past(wr_tag)) && !ents[$past(wr_arch)].rdy);
endmodule

// File: rtl/reg_rename_map.sv
`timescale 1ns/1ps
module reg_rename_map #(
    parameter int NUM_ARCH = rrm_pkg::DEF_NUM_ARCH,
    parameter int NUM_PHYS = rrm_pkg::DEF_NUM_PHYS,
    parameter int DATA_W   = rrm_pkg::DEF_DATA_W
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    disp_valid,
    input  logic [rrm_pkg::width_of(NUM_ARCH)-1:0]  disp_src_a,
    input  logic [rrm_pkg::width_of(NUM_ARCH)-1:0]  disp_src_b,
    input  logic [rrm_pkg::width_of(NUM_ARCH)-1:0]  disp_dst,
    input  logic                                    wb_valid,
    input  logic [rrm_pkg::width_of(NUM_PHYS)-1:0]  wb_tag,
    input  logic [DATA_W-1:0]                       wb_data,
    input  logic                                    rel_valid,
    input  logic [rrm_pkg::width_of(NUM_PHYS)-1:0]  rel_tag,
    output logic                                    disp_ready,
    output logic [rrm_pkg::width_of(NUM_PHYS)-1:0]  dst_tag,
    output logic                                    src_a_rdy,
    output logic [DATA_W-1:0]                       src_a_opnd,
    output logic                                    src_b_rdy,
    output logic [DATA_W-1:0]                       src_b_opnd
);
    import rrm_pkg::*;

    localparam int ARCH_W = width_of(NUM_ARCH);
    localparam int TAG_W  = width_of(NUM_PHYS);
    localparam int NRD    = 2;

    logic              fl_nonempty;
    logic [TAG_W-1:0]  fl_head;
    logic              disp_fire;
    logic [ARCH_W-1:0] src_arch [NRD];
    logic [TAG_W-1:0]  map_tag  [NRD];
    logic              map_rdy  [NRD];
    logic [DATA_W-1:0] prf_rd   [NRD];
    logic [NUM_PHYS-1:0] phys_vld;
    opnd_src_e         sel      [NRD];
    logic              res_rdy  [NRD];
    logic [DATA_W-1:0] res_opnd [NRD];

    assign disp_fire   = disp_valid && fl_nonempty;
    assign disp_ready  = fl_nonempty;
    assign dst_tag     = fl_head;
    assign src_arch[0] = disp_src_a;
    assign src_arch[1] = disp_src_b;

    rrm_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) free_i (
        .clk      (clk),
        .rst      (rst),
        .pop      (disp_fire),
        .push     (rel_valid),
        .push_tag (rel_tag),
        .head_tag (fl_head),
        .nonempty (fl_nonempty)
    );

    rrm_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NRD(NRD)) map_i (
        .clk      (clk),
        .rst      (rst),
        .rd_arch  (src_arch),
        .rd_tag   (map_tag),
        .rd_rdy   (map_rdy),
        .wr_en    (disp_fire),
        .wr_arch  (disp_dst),
        .wr_tag   (fl_head),
        .wb_valid (wb_valid),
        .wb_tag   (wb_tag)
    );

    rrm_phys_file #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS),
                    .DATA_W(DATA_W), .NRD(NRD)) prf_i (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (disp_fire),
        .alloc_tag (fl_head),
        .wb_valid  (wb_valid),
        .wb_tag    (wb_tag),
        .wb_data   (wb_data),
        .rd_tag    (map_tag),
        .rd_data   (prf_rd),
        .vld       (phys_vld)
    );

    // Per-source operand resolution: stored value, bypass, or tag
    for (genvar g = 0; g < NRD; g++) begin : g_src
        always_comb begin
            if (map_rdy[g])
                sel[g] = OPND_PRF;
            else if (wb_valid && wb_tag == map_tag[g])
                sel[g] = OPND_FWD;
            else
                sel[g] = OPND_TAG;
            case (sel[g])
                OPND_PRF: begin res_rdy[g] = 1'b1; res_opnd[g] = prf_rd[g]; end
                OPND_FWD: begin res_rdy[g] = 1'b1; res_opnd[g] = wb_data;   end
                default:  begin
                    res_rdy[g]  = 1'b0;
                    res_opnd[g] = {{(DATA_W-TAG_W){1'b0}}, map_tag[g]};
                end
            endcase
        end

        // R7: a ready mapping is always backed by a valid physical register
        p_ready_backed_r7: assert property (@(posedge clk) disable iff (rst)
            map_rdy[g] |-> phys_vld[map_tag[g]]);
    end

    assign src_a_rdy  = res_rdy[0];
    assign src_a_opnd = res_opnd[0];
    assign src_b_rdy  = res_rdy[1];
    assign src_b_opnd = res_opnd[1];

    // R2: sources always name an existing architectural register
    p_src_range_r2: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_src_a < ARCH_W'(NUM_ARCH)) && (disp_src_b < ARCH_W'(NUM_ARCH)));
    // R4: an allocated tag is never a register that still holds a live value
    p_alloc_free_r4: assert property (@(posedge clk) disable iff (rst)
        disp_fire |-> !(wb_valid && wb_tag == fl_head));
endmodule

// File: tb/reg_rename_map_tb_top.sv
`timescale 1ns/1ps
module reg_rename_map_tb_top;
    localparam int AW = 3;
    localparam int TW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          disp_valid;
    logic [AW-1:0] disp_src_a, disp_src_b, disp_dst;
    logic          wb_valid;
    logic [TW-1:0] wb_tag;
    logic [DW-1:0] wb_data;
    logic          rel_valid;
    logic [TW-1:0] rel_tag;
    logic          disp_ready;
    logic [TW-1:0] dst_tag;
    logic          src_a_rdy, src_b_rdy;
    logic [DW-1:0] src_a_opnd, src_b_opnd;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;  // 50 MHz

    reg_rename_map dut_i (
        .clk(clk), .rst(rst), .disp_valid(disp_valid),
        .disp_src_a(disp_src_a), .disp_src_b(disp_src_b), .disp_dst(disp_dst),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .rel_valid(rel_valid), .rel_tag(rel_tag),
        .disp_ready(disp_ready), .dst_tag(dst_tag),
        .src_a_rdy(src_a_rdy), .src_a_opnd(src_a_opnd),
        .src_b_rdy(src_b_rdy), .src_b_opnd(src_b_opnd)
    );

    typedef struct packed {
        logic          dv;
        logic [AW-1:0] sa, sb, dst;
        logic          wbv;
        logic [TW-1:0] wbt;
        logic [DW-1:0] wbd;
        logic          fv;
        logic [TW-1:0] ft;
        logic          e_rdy;
        logic          e_ar;
        logic [DW-1:0] e_aop;
        logic          e_br;
        logic [DW-1:0] e_bop;
        logic [TW-1:0] e_dt;
    } vec_t;

    localparam int NV = 12;
    // Reset state: Ri -> Pi ready with value 0; free list P5, P6, P7.
    localparam vec_t TBL [NV] = '{
        // R4: src R1 with dst R1 sees the old ready mapping; R1 -> P5
        '{1'b1,3'd1,3'd2,3'd1, 1'b0,3'd0,16'h0,    1'b0,3'd0, 1'b1, 1'b1,16'h0,    1'b1,16'h0,    3'd5},
        // R3: R1 pending on P5 hands out the tag; R2 -> P6
        '{1'b1,3'd1,3'd3,3'd2, 1'b0,3'd0,16'h0,    1'b0,3'd0, 1'b1, 1'b0,16'h5,    1'b1,16'h0,    3'd6},
        // R5: R1 remapped again while P5 is still pending; R1 -> P7
        '{1'b1,3'd4,3'd4,3'd1, 1'b0,3'd0,16'h0,    1'b0,3'd0, 1'b1, 1'b1,16'h0,    1'b1,16'h0,    3'd7},
        // R6: list empty, dispatch to R0 does not fire; R1 shows newest tag P7
        '{1'b1,3'd1,3'd2,3'd0, 1'b0,3'd0,16'h0,    1'b0,3'd0, 1'b0, 1'b0,16'h7,    1'b0,16'h6,    3'd0},
        // R7: writeback of stale P5 leaves R1 (now P7) pending
        '{1'b0,3'd1,3'd2,3'd0, 1'b1,3'd5,16'h1111, 1'b0,3'd0, 1'b0, 1'b0,16'h7,    1'b0,16'h6,    3'd0},
        // R8: writeback of P7 is forwarded to a source of R1; stalled dst R3
        '{1'b1,3'd1,3'd0,3'd3, 1'b1,3'd7,16'h2222, 1'b0,3'd0, 1'b0, 1'b1,16'h2222, 1'b1,16'h0,    3'd0},
        // R10: release P5; disp_ready stays low in this cycle
        '{1'b0,3'd1,3'd2,3'd0, 1'b0,3'd0,16'h0,    1'b1,3'd5, 1'b0, 1'b1,16'h2222, 1'b0,16'h6,    3'd0},
        // R9/R10: dst R2 -> P5 while old tag P6 writes back; source R2 forwards
        '{1'b1,3'd1,3'd2,3'd2, 1'b1,3'd6,16'h3333, 1'b0,3'd0, 1'b1, 1'b1,16'h2222, 1'b1,16'h3333, 3'd5},
        // R9: R2 now waits on P5 despite the P6 writeback
        '{1'b0,3'd2,3'd1,3'd0, 1'b0,3'd0,16'h0,    1'b0,3'd0, 1'b0, 1'b0,16'h5,    1'b1,16'h2222, 3'd0},
        // R2: untouched registers still ready with 0
        '{1'b0,3'd0,3'd4,3'd0, 1'b1,3'd5,16'h4444, 1'b0,3'd0, 1'b0, 1'b1,16'h0,    1'b1,16'h0,    3'd0},
        // R7: R2 became ready with the P5 value
        '{1'b0,3'd2,3'd2,3'd0, 1'b0,3'd0,16'h0,    1'b0,3'd0, 1'b0, 1'b1,16'h4444, 1'b1,16'h4444, 3'd0},
        // R6: stalled dispatch to R3 left its mapping alone
        '{1'b0,3'd3,3'd0,3'd0, 1'b0,3'd0,16'h0,    1'b0,3'd0, 1'b0, 1'b1,16'h0,    1'b1,16'h0,    3'd0}
    };

    task automatic chk(input string req, input int row, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s step %0d: actual=%h expected=%h", req, row, act, exp);
        end
    endtask

    task automatic drive(input logic dv, input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                         input logic [AW-1:0] dst, input logic wbv, input logic [TW-1:0] wbt,
                         input logic [DW-1:0] wbd, input logic fv, input logic [TW-1:0] ft);
        @(negedge clk);
        disp_valid = dv; disp_src_a = sa; disp_src_b = sb; disp_dst = dst;
        wb_valid = wbv; wb_tag = wbt; wb_data = wbd;
        rel_valid = fv; rel_tag = ft;
        #5;
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, '0, 1'b0, '0, '0, 1'b0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        disp_valid = 1'b0; disp_src_a = '0; disp_src_b = '0; disp_dst = '0;
        wb_valid = 1'b0; wb_tag = '0; wb_data = '0; rel_valid = 1'b0; rel_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state seen at the ports
        drive(1'b0, 3'd1, 3'd4, 3'd0, 1'b0, '0, '0, 1'b0, '0);
        chk("R1 disp_ready", 0, 32'(disp_ready), 32'd1);
        chk("R1 src_a_rdy",  0, 32'(src_a_rdy),  32'd1);
        chk("R1 src_a_opnd", 0, 32'(src_a_opnd), 32'd0);
        chk("R1 src_b_rdy",  0, 32'(src_b_rdy),  32'd1);
        chk("R1 dst_tag",    0, 32'(dst_tag),    32'd5);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].dv, TBL[i].sa, TBL[i].sb, TBL[i].dst,
                  TBL[i].wbv, TBL[i].wbt, TBL[i].wbd, TBL[i].fv, TBL[i].ft);
            chk("R6/R10 disp_ready", i+1, 32'(disp_ready), 32'(TBL[i].e_rdy));
            chk("R2/R3/R8 src_a_rdy",  i+1, 32'(src_a_rdy),  32'(TBL[i].e_ar));
            chk("R2/R3/R8 src_a_opnd", i+1, 32'(src_a_opnd), 32'(TBL[i].e_aop));
            chk("R2/R3/R8 src_b_rdy",  i+1, 32'(src_b_rdy),  32'(TBL[i].e_br));
            chk("R2/R3/R8 src_b_opnd", i+1, 32'(src_b_opnd), 32'(TBL[i].e_bop));
            if (TBL[i].dv && TBL[i].e_rdy)
                chk("R4 dst_tag", i+1, 32'(dst_tag), 32'(TBL[i].e_dt));
        end

        // R1: reset mid-run restores the identity map and the free-list order
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 3'd2, 3'd1, 3'd0, 1'b0, '0, '0, 1'b0, '0);
        chk("R1 reset src_a_rdy",  20, 32'(src_a_rdy),  32'd1);
        chk("R1 reset src_a_opnd", 20, 32'(src_a_opnd), 32'd0);
        chk("R1 reset dst_tag",    20, 32'(dst_tag),    32'd5);

        // R5: second write to R0 while P5 pending; readers see P6
        drive(1'b1, 3'd0, 3'd0, 3'd0, 1'b0, '0, '0, 1'b0, '0);
        chk("R3 src_a_opnd pending", 21, 32'(src_a_opnd), 32'd5);
        chk("R5 dst_tag",            21, 32'(dst_tag),    32'd6);
        idle();
        chk("R5 newest tag", 22, 32'(src_a_opnd), 32'd6);
        chk("R5 not ready",  22, 32'(src_a_rdy),  32'd0);

        // R10: drain, release P6, and allocate it from the next cycle
        drive(1'b1, 3'd3, 3'd3, 3'd3, 1'b0, '0, '0, 1'b0, '0);
        chk("R4 dst_tag last", 23, 32'(dst_tag), 32'd7);
        drive(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, '0, '0, 1'b1, 3'd6);
        chk("R6 empty", 24, 32'(disp_ready), 32'd0);
        drive(1'b1, 3'd0, 3'd0, 3'd4, 1'b0, '0, '0, 1'b0, '0);
        chk("R10 ready after release", 25, 32'(disp_ready), 32'd1);
        chk("R10 reused tag",          25, 32'(dst_tag),    32'd6);
        idle();
        chk("R6 empty again", 26, 32'(disp_ready), 32'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule